// File: doc/BRIEF.md
# System Bus Address Decoder

This block steers each access from a 32-bit processor bus to one of six target ports: boot ROM, external work RAM, internal work RAM, I/O registers, the graphics memories and the cartridge. The top byte of the address names a region. Each region has its own rule for folding the offset, and that rule also depends on the access size. The decoder drives a select line, an offset, a write enable and write data to the targets within the same cycle as the request. It registers the read data that comes back, so that data appears on the response bus one clock edge later.

Regions that no target claims read as zero and ignore writes. Writes to read-only regions are also dropped. A side-effect-free debug read lets an inspection tool look at any byte without triggering I/O read side effects.

Top module: `sysbus_decoder`

## Requirements
- R1: The region is chosen from `req_addr[31:24]` alone. `tgt_sel` is one-hot or zero, with bit 0 for boot ROM, 1 for external RAM, 2 for internal RAM, 3 for I/O, 4 for graphics and 5 for cartridge. Default region codes are 0x00 boot, 0x02 external RAM, 0x03 internal RAM, 0x04 I/O, 0x05/0x06/0x07 graphics, 0x08..0x0D cartridge ROM and 0x0E/0x0F save RAM.
- R2: The external RAM offset is the address ANDed with 0x3FFFF (byte), 0x3FFFE (halfword) or 0x3FFFC (word).
- R3: The internal RAM offset is the address ANDed with 0x7FFF, 0x7FFE or 0x7FFC, by size.
- R4: In the I/O region, if the size-aligned `req_addr[15:0]` equals 0x8000, the offset is 0x800. Otherwise the offset is the address ANDed with 0x7FF, 0x7FE or 0x7FC, by size.
- R5: The three graphics region codes all select the graphics port and pass the full 32-bit address unchanged.
- R6: Reads from any region 0x08..0x0F select the cartridge with the full address. Writes reach the cartridge only for 0x08, 0x0D, 0x0E and 0x0F. Writes to the other cartridge codes assert no select and no write enable.
- R7: Boot ROM reads select port 0 with the full address. Boot ROM writes assert no select and no write enable.
- R8: An access to an unmapped region asserts no select. A read from it returns zero on `resp_rdata`, and a write to it asserts no write enable.
- R9: Size code 11 behaves as unmapped in every region. Size codes are 00 byte, 01 halfword and 10 word.
- R10: `resp_rdata` is registered. It holds the selected target's read data one edge after the request, masked to 8 bits for bytes and 16 bits for halfwords. It is zero after a cycle with no mapped read and zero after reset.
- R11: `tgt_wdata` is the low byte, the low halfword or the full word of `req_wdata`, zero-extended. `tgt_we` is only high for a routed write.
- R12: `io_rd_strobe` is high for a normal read routed to I/O. `req_debug` forces a byte read with identical routing and keeps `io_rd_strobe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 invalid |
| req_addr | input | 32 | Access address |
| req_wdata | input | 32 | Write data, low lanes used |
| req_debug | input | 1 | Side-effect-free byte read |
| tgt_sel | output | 6 | One select per target port |
| tgt_addr | output | 32 | Folded offset or full address to the selected target |
| tgt_size | output | 2 | Effective access size |
| tgt_we | output | 1 | Write enable to the selected target |
| tgt_wdata | output | 32 | Zero-extended write data |
| io_rd_strobe | output | 1 | I/O read with side effects |
| rom_rdata | input | 32 | Boot ROM read data |
| xram_rdata | input | 32 | External RAM read data |
| iram_rdata | input | 32 | Internal RAM read data |
| io_rdata | input | 32 | I/O read data |
| gfx_rdata | input | 32 | Graphics read data |
| cart_rdata | input | 32 | Cartridge read data |
| resp_rdata | output | 32 | Registered read response |

## Verification
Selects, offsets, write enable, write data and the I/O strobe are combinational. They are due in the same cycle as the request, so the bench drives each request just after a falling edge and checks these outputs 2 ns later, before the next rising edge. Read data comes through one register and is due after the first rising edge that follows the request, so the bench samples `resp_rdata` 2 ns after that edge. The behavioural target models derive their data from `tgt_addr` and the port index, which makes a wrong route or a wrong fold show up in the response value. Reset is checked by holding a mapped read during reset and seeing a zero response.

// File: rtl/sysbus_pkg.sv
`timescale 1ns/1ps
package sysbus_pkg;

    localparam int NUM_TGT   = 6;
    localparam int TGT_IDX_W = $clog2(NUM_TGT);

    localparam int TGT_BOOT = 0;
    localparam int TGT_XRAM = 1;
    localparam int TGT_IRAM = 2;
    localparam int TGT_IO   = 3;
    localparam int TGT_GFX  = 4;
    localparam int TGT_CART = 5;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } acc_size_e;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_BOOT,
        RG_XRAM,
        RG_IRAM,
        RG_IO,
        RG_GFX,
        RG_CART_WR,
        RG_CART_RO
    } region_e;

    // Effective request after the debug override is applied
    typedef struct packed {
        logic      valid;
        logic      write;
        logic      debug;
        acc_size_e size;
        logic [31:0] addr;
    } bus_req_t;

    // Route decision for one cycle
    typedef struct packed {
        logic [TGT_IDX_W-1:0] idx;
        logic                 mapped;
        logic                 writable;
    } route_t;

    // Clears the address bits below the access width
    function automatic logic [31:0] size_align_mask(acc_size_e sz);
        case (sz)
            SZ_HALF: return 32'hFFFF_FFFE;
            SZ_WORD: return 32'hFFFF_FFFC;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // Keeps only the data lanes the access size covers
    function automatic logic [31:0] lane_mask(acc_size_e sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic route_t region_route(region_e rg);
        route_t r;
        r = '{idx: '0, mapped: 1'b0, writable: 1'b0};
        case (rg)
            RG_BOOT:    r = '{idx: TGT_IDX_W'(TGT_BOOT), mapped: 1'b1, writable: 1'b0};
            RG_XRAM:    r = '{idx: TGT_IDX_W'(TGT_XRAM), mapped: 1'b1, writable: 1'b1};
            RG_IRAM:    r = '{idx: TGT_IDX_W'(TGT_IRAM), mapped: 1'b1, writable: 1'b1};
            RG_IO:      r = '{idx: TGT_IDX_W'(TGT_IO),   mapped: 1'b1, writable: 1'b1};
            RG_GFX:     r = '{idx: TGT_IDX_W'(TGT_GFX),  mapped: 1'b1, writable: 1'b1};
            RG_CART_WR: r = '{idx: TGT_IDX_W'(TGT_CART), mapped: 1'b1, writable: 1'b1};
            RG_CART_RO: r = '{idx: TGT_IDX_W'(TGT_CART), mapped: 1'b1, writable: 1'b0};
            default:    r = '{idx: '0, mapped: 1'b0, writable: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sysbus_region_decode.sv
`timescale 1ns/1ps
module sysbus_region_decode
    import sysbus_pkg::*;
#(
    parameter logic [7:0] BOOT_PAGE  = 8'h00,
    parameter logic [7:0] XRAM_PAGE  = 8'h02,
    parameter logic [7:0] IRAM_PAGE  = 8'h03,
    parameter logic [7:0] IO_PAGE    = 8'h04,
    parameter logic [7:0] PAL_PAGE   = 8'h05,
    parameter logic [7:0] VRAM_PAGE  = 8'h06,
    parameter logic [7:0] OAM_PAGE   = 8'h07,
    parameter logic [7:0] CART_FIRST = 8'h08,
    parameter logic [7:0] CART_LAST  = 8'h0D,
    parameter logic [7:0] SAVE_FIRST = 8'h0E,
    parameter logic [7:0] SAVE_LAST  = 8'h0F
) (
    input  logic [7:0] page,
    output region_e    region
);
    logic in_cart;
    logic in_save;
    logic cart_wr_edge;

    always_comb begin
        in_cart      = (page >= CART_FIRST) && (page <= CART_LAST);
        in_save      = (page >= SAVE_FIRST) && (page <= SAVE_LAST);
        cart_wr_edge = (page == CART_FIRST) || (page == CART_LAST);

        if (page == BOOT_PAGE)
            region = RG_BOOT;
        else if (page == XRAM_PAGE)
            region = RG_XRAM;
        else if (page == IRAM_PAGE)
            region = RG_IRAM;
        else if (page == IO_PAGE)
            region = RG_IO;
        else if ((page == PAL_PAGE) || (page == VRAM_PAGE) || (page == OAM_PAGE))
            region = RG_GFX;
        else if (in_save || (in_cart && cart_wr_edge))
            region = RG_CART_WR;
        else if (in_cart)
            region = RG_CART_RO;
        else
            region = RG_NONE;
    end

endmodule

// File: rtl/sysbus_addr_fold.sv
`timescale 1ns/1ps
module sysbus_addr_fold
    import sysbus_pkg::*;
#(
    parameter int unsigned XRAM_AW      = 18,
    parameter int unsigned IRAM_AW      = 15,
    parameter int unsigned IO_AW        = 11,
    parameter logic [15:0] IO_ALIAS_LOW = 16'h8000,
    parameter logic [31:0] IO_ALIAS_OFS = 32'h0000_0800
) (
    input  region_e     region,
    input  acc_size_e   size,
    input  logic [31:0] addr,
    output logic [31:0] offset
);
    localparam logic [31:0] XRAM_MASK = (32'h1 << XRAM_AW) - 32'h1;
    localparam logic [31:0] IRAM_MASK = (32'h1 << IRAM_AW) - 32'h1;
    localparam logic [31:0] IO_MASK   = (32'h1 << IO_AW) - 32'h1;

    logic [31:0] amask;
    logic        io_alias_hit;

    always_comb begin
        amask        = size_align_mask(size);
        io_alias_hit = ((addr[15:0] & amask[15:0]) == IO_ALIAS_LOW);
        case (region)
            RG_XRAM: offset = addr & XRAM_MASK & amask;
            RG_IRAM: offset = addr & IRAM_MASK & amask;
            RG_IO:   offset = io_alias_hit ? IO_ALIAS_OFS : (addr & IO_MASK & amask);
            default: offset = addr;
        endcase
    end

endmodule

// File: rtl/sysbus_route.sv
`timescale 1ns/1ps
module sysbus_route
    import sysbus_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           req,
    input  region_e            region,
    output logic [NUM_TGT-1:0] sel,
    output logic               we,
    output logic               io_rd
);
    route_t rt;
    logic   go;

    always_comb begin
        rt = region_route(region);
        go = req.valid && (req.size != SZ_BAD) && rt.mapped
             && (!req.write || rt.writable);
    end

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_sel
        assign sel[t] = go && (rt.idx == TGT_IDX_W'(t));
    end

    assign we    = go && req.write;
    assign io_rd = go && !req.write && !req.debug && (rt.idx == TGT_IDX_W'(TGT_IO));

    // R1: never more than one target selected
    a_r1_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

    // R9: invalid size code never reaches a target
    a_r9_bad_size_idle: assert property (@(posedge clk) disable iff (rst)
        (req.size == SZ_BAD) |-> (sel == '0));

endmodule

// File: rtl/sysbus_read_return.sv
`timescale 1ns/1ps
module sysbus_read_return
    import sysbus_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_TGT-1:0] sel,
    input  logic               rd,
    input  acc_size_e          size,
    input  logic [31:0]        src [NUM_TGT],
    output logic [31:0]        resp
);
    logic [31:0] picked [NUM_TGT];
    logic [31:0] merged;
    logic [31:0] resp_d;

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_pick
        assign picked[t] = sel[t] ? src[t] : 32'h0;
    end

    always_comb begin
        merged = 32'h0;
        for (int t = 0; t < NUM_TGT; t++)
            merged = merged | picked[t];
        resp_d = rd ? (merged & lane_mask(size)) : 32'h0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            resp <= 32'h0;
        else
            resp <= resp_d;
    end

    // R10: byte reads come back with the upper lanes cleared
    a_r10_byte_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (rd && size == SZ_BYTE) |=> (resp[31:8] == 24'h0));

    // R10: no read this cycle gives a zero response next cycle
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (!rd) |=> (resp == 32'h0));

endmodule

// File: rtl/sysbus_decoder.sv
`timescale 1ns/1ps
module sysbus_decoder
    import sysbus_pkg::*;
#(
    parameter logic [7:0]  BOOT_PAGE    = 8'h00,
    parameter logic [7:0]  XRAM_PAGE    = 8'h02,
    parameter logic [7:0]  IRAM_PAGE    = 8'h03,
    parameter logic [7:0]  IO_PAGE      = 8'h04,
    parameter logic [7:0]  PAL_PAGE     = 8'h05,
    parameter logic [7:0]  VRAM_PAGE    = 8'h06,
    parameter logic [7:0]  OAM_PAGE     = 8'h07,
    parameter logic [7:0]  CART_FIRST   = 8'h08,
    parameter logic [7:0]  CART_LAST    = 8'h0D,
    parameter logic [7:0]  SAVE_FIRST   = 8'h0E,
    parameter logic [7:0]  SAVE_LAST    = 8'h0F,
    parameter int unsigned XRAM_AW      = 18,
    parameter int unsigned IRAM_AW      = 15,
    parameter int unsigned IO_AW        = 11,
    parameter logic [15:0] IO_ALIAS_LOW = 16'h8000,
    parameter logic [31:0] IO_ALIAS_OFS = 32'h0000_0800
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic        req_debug,
    output logic [5:0]  tgt_sel,
    output logic [31:0] tgt_addr,
    output logic [1:0]  tgt_size,
    output logic        tgt_we,
    output logic [31:0] tgt_wdata,
    output logic        io_rd_strobe,
    input  logic [31:0] rom_rdata,
    input  logic [31:0] xram_rdata,
    input  logic [31:0] iram_rdata,
    input  logic [31:0] io_rdata,
    input  logic [31:0] gfx_rdata,
    input  logic [31:0] cart_rdata,
    output logic [31:0] resp_rdata
);
    bus_req_t    req;
    region_e     region;
    logic [31:0] src [NUM_TGT];
    logic [NUM_TGT-1:0] sel;
    logic        we;

    // Debug access: forced byte read, same routing, no side effects
    always_comb begin
        req.valid = req_valid || req_debug;
        req.write = req_debug ? 1'b0 : req_write;
        req.debug = req_debug;
        req.size  = req_debug ? SZ_BYTE : acc_size_e'(req_size);
        req.addr  = req_addr;
    end

    sysbus_region_decode #(
        .BOOT_PAGE (BOOT_PAGE),  .XRAM_PAGE (XRAM_PAGE), .IRAM_PAGE (IRAM_PAGE),
        .IO_PAGE   (IO_PAGE),    .PAL_PAGE  (PAL_PAGE),  .VRAM_PAGE (VRAM_PAGE),
        .OAM_PAGE  (OAM_PAGE),   .CART_FIRST(CART_FIRST), .CART_LAST(CART_LAST),
        .SAVE_FIRST(SAVE_FIRST), .SAVE_LAST (SAVE_LAST)
    ) u_region (
        .page   (req.addr[31:24]),
        .region (region)
    );

    sysbus_addr_fold #(
        .XRAM_AW     (XRAM_AW),
        .IRAM_AW     (IRAM_AW),
        .IO_AW       (IO_AW),
        .IO_ALIAS_LOW(IO_ALIAS_LOW),
        .IO_ALIAS_OFS(IO_ALIAS_OFS)
    ) u_fold (
        .region (region),
        .size   (req.size),
        .addr   (req.addr),
        .offset (tgt_addr)
    );

    sysbus_route u_route (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .region (region),
        .sel    (sel),
        .we     (we),
        .io_rd  (io_rd_strobe)
    );

    assign src[TGT_BOOT] = rom_rdata;
    assign src[TGT_XRAM] = xram_rdata;
    assign src[TGT_IRAM] = iram_rdata;
    assign src[TGT_IO]   = io_rdata;
    assign src[TGT_GFX]  = gfx_rdata;
    assign src[TGT_CART] = cart_rdata;

    sysbus_read_return u_ret (
        .clk  (clk),
        .rst  (rst),
        .sel  (sel),
        .rd   ((|sel) && !we),
        .size (req.size),
        .src  (src),
        .resp (resp_rdata)
    );

    assign tgt_sel   = sel;
    assign tgt_we    = we;
    assign tgt_size  = req.size;
    assign tgt_wdata = req_wdata & lane_mask(req.size);

    // R7: boot ROM never receives a write
    a_r7_rom_no_write: assert property (@(posedge clk) disable iff (rst)
        tgt_we |-> !tgt_sel[TGT_BOOT]);

    // R12: debug reads never strobe the I/O port
    a_r12_debug_quiet: assert property (@(posedge clk) disable iff (rst)
        req_debug |-> (!io_rd_strobe && !tgt_we));

    // R11: a read request never produces a write enable
    a_r11_no_we_on_read: assert property (@(posedge clk) disable iff (rst)
        !req_write |-> !tgt_we);

    // R2: external RAM offset stays inside its mirror window
    a_r2_xram_window: assert property (@(posedge clk) disable iff (rst)
        tgt_sel[TGT_XRAM] |-> ((tgt_addr >> XRAM_AW) == 32'h0));

    // R6: cartridge writes only from the writable page codes
    a_r6_cart_write_pages: assert property (@(posedge clk) disable iff (rst)
        (tgt_we && tgt_sel[TGT_CART]) |->
        ((req_addr[31:24] == CART_FIRST) || (req_addr[31:24] == CART_LAST) ||
         ((req_addr[31:24] >= SAVE_FIRST) && (req_addr[31:24] <= SAVE_LAST))));

endmodule

// File: tb/test_sysbus_decoder.sv
`timescale 1ns/1ps
module test_sysbus_decoder;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_debug;
    logic [1:0]  req_size;
    logic [31:0] req_addr, req_wdata;
    logic [5:0]  tgt_sel;
    logic [31:0] tgt_addr, tgt_wdata, resp_rdata;
    logic [1:0]  tgt_size;
    logic        tgt_we, io_rd_strobe;
    logic [31:0] rom_rdata, xram_rdata, iram_rdata, io_rdata, gfx_rdata, cart_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    // Behavioural targets: data encodes port index and received offset
    function automatic logic [31:0] pat(int k, logic [31:0] a);
        return {4'(k + 1), a[27:0]} ^ (32'(k + 1) << 4);
    endfunction

    assign rom_rdata  = pat(0, tgt_addr);
    assign xram_rdata = pat(1, tgt_addr);
    assign iram_rdata = pat(2, tgt_addr);
    assign io_rdata   = pat(3, tgt_addr);
    assign gfx_rdata  = pat(4, tgt_addr);
    assign cart_rdata = pat(5, tgt_addr);

    sysbus_decoder i_sysbus_decoder (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_debug(req_debug),
        .tgt_sel(tgt_sel), .tgt_addr(tgt_addr), .tgt_size(tgt_size),
        .tgt_we(tgt_we), .tgt_wdata(tgt_wdata), .io_rd_strobe(io_rd_strobe),
        .rom_rdata(rom_rdata), .xram_rdata(xram_rdata), .iram_rdata(iram_rdata),
        .io_rdata(io_rdata), .gfx_rdata(gfx_rdata), .cart_rdata(cart_rdata),
        .resp_rdata(resp_rdata)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [31:0] a;
        logic [31:0] wd;
        logic [5:0]  sel;
        logic [31:0] ta;
        logic        we;
        logic [31:0] twd;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd2, 32'h0000_0104, 32'h0, 6'b000001, 32'h0000_0104, 1'b0, 32'h0},         // R7 rom read
        '{1'b0, 2'd0, 32'h0204_5677, 32'h0, 6'b000010, 32'h0000_5677, 1'b0, 32'h0},         // R2 byte mirror
        '{1'b0, 2'd1, 32'h0200_1235, 32'h0, 6'b000010, 32'h0000_1234, 1'b0, 32'h0},         // R2 half
        '{1'b0, 2'd2, 32'h027F_FFFF, 32'h0, 6'b000010, 32'h0003_FFFC, 1'b0, 32'h0},         // R2 word
        '{1'b0, 2'd0, 32'h0300_9ABC, 32'h0, 6'b000100, 32'h0000_1ABC, 1'b0, 32'h0},         // R3 byte
        '{1'b0, 2'd2, 32'h0312_3457, 32'h0, 6'b000100, 32'h0000_3454, 1'b0, 32'h0},         // R3 word
        '{1'b0, 2'd1, 32'h0400_0131, 32'h0, 6'b001000, 32'h0000_0130, 1'b0, 32'h0},         // R4 half
        '{1'b0, 2'd2, 32'h0400_8002, 32'h0, 6'b001000, 32'h0000_0800, 1'b0, 32'h0},         // R4 alias word
        '{1'b0, 2'd0, 32'h0400_8002, 32'h0, 6'b001000, 32'h0000_0002, 1'b0, 32'h0},         // R4 no alias byte
        '{1'b0, 2'd1, 32'h0401_8001, 32'h0, 6'b001000, 32'h0000_0800, 1'b0, 32'h0},         // R4 alias half
        '{1'b0, 2'd2, 32'h0500_0010, 32'h0, 6'b010000, 32'h0500_0010, 1'b0, 32'h0},         // R5 palette
        '{1'b0, 2'd1, 32'h0600_1002, 32'h0, 6'b010000, 32'h0600_1002, 1'b0, 32'h0},         // R5 video
        '{1'b0, 2'd0, 32'h0700_0003, 32'h0, 6'b010000, 32'h0700_0003, 1'b0, 32'h0},         // R5 object
        '{1'b0, 2'd2, 32'h0A00_0040, 32'h0, 6'b100000, 32'h0A00_0040, 1'b0, 32'h0},         // R6 rom read
        '{1'b0, 2'd0, 32'h0F00_0001, 32'h0, 6'b100000, 32'h0F00_0001, 1'b0, 32'h0},         // R6 save read
        '{1'b0, 2'd2, 32'h1000_0000, 32'h0, 6'b000000, 32'h0,         1'b0, 32'h0},         // R8 unmapped
        '{1'b0, 2'd0, 32'h0100_0000, 32'h0, 6'b000000, 32'h0,         1'b0, 32'h0},         // R8 hole
        '{1'b0, 2'd3, 32'h0200_0000, 32'h0, 6'b000000, 32'h0,         1'b0, 32'h0},         // R9 bad size
        '{1'b1, 2'd2, 32'h0200_0008, 32'hDEAD_BEEF, 6'b000010, 32'h8, 1'b1, 32'hDEAD_BEEF}, // R11 word
        '{1'b1, 2'd0, 32'h0300_0001, 32'h1234_56AB, 6'b000100, 32'h1, 1'b1, 32'h0000_00AB}, // R11 byte
        '{1'b1, 2'd1, 32'h0400_0002, 32'hCAFE_F00D, 6'b001000, 32'h2, 1'b1, 32'h0000_F00D}, // R11 half
        '{1'b1, 2'd2, 32'h0000_0000, 32'h1111_1111, 6'b000000, 32'h0, 1'b0, 32'h0},         // R7 rom write
        '{1'b1, 2'd2, 32'h0800_0000, 32'h2222_2222, 6'b100000, 32'h0800_0000, 1'b1, 32'h2222_2222}, // R6
        '{1'b1, 2'd2, 32'h0A00_0000, 32'h3333_3333, 6'b000000, 32'h0, 1'b0, 32'h0},         // R6 dropped
        '{1'b1, 2'd2, 32'h0D00_0004, 32'h4444_4444, 6'b100000, 32'h0D00_0004, 1'b1, 32'h4444_4444}, // R6
        '{1'b1, 2'd0, 32'h0E00_0001, 32'h5555_5566, 6'b100000, 32'h0E00_0001, 1'b1, 32'h66}, // R6 save
        '{1'b1, 2'd2, 32'h0900_0000, 32'h6666_6666, 6'b000000, 32'h0, 1'b0, 32'h0},         // R6 dropped
        '{1'b1, 2'd2, 32'h2000_0000, 32'h7777_7777, 6'b000000, 32'h0, 1'b0, 32'h0},         // R8 write
        '{1'b1, 2'd3, 32'h0300_0000, 32'h8888_8888, 6'b000000, 32'h0, 1'b0, 32'h0}          // R9 write
    };

    function automatic logic [31:0] exp_resp(logic wr, logic [1:0] sz,
                                             logic [5:0] sel, logic [31:0] ta);
        logic [31:0] v;
        v = 32'h0;
        if (!wr) begin
            for (int k = 0; k < 6; k++)
                if (sel[k]) v = pat(k, ta);
            if (sz == 2'd0) v = v & 32'hFF;
            else if (sz == 2'd1) v = v & 32'hFFFF;
        end
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic w, input logic [1:0] s,
                         input logic [31:0] a, input logic [31:0] d, input logic dbg);
        req_valid = v; req_write = w; req_size = s;
        req_addr = a; req_wdata = d; req_debug = dbg;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0);
        // R10 reset: mapped read held during reset gives zero response
        @(negedge clk);
        drive(1'b1, 1'b0, 2'd2, 32'h0200_0010, 32'h0, 1'b0);
        @(posedge clk); #2;
        chk(resp_rdata == 32'h0, "R10 reset response", resp_rdata, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0);
        #2;
        chk(tgt_sel == 6'h0, "R1 idle select", 32'(tgt_sel), 32'h0);
        @(posedge clk); #2;
        chk(resp_rdata == 32'h0, "R10 idle response", resp_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(1'b1, VECS[i].wr, VECS[i].sz, VECS[i].a, VECS[i].wd, 1'b0);
            #2;
            chk(tgt_sel == VECS[i].sel, $sformatf("R1 select vec %0d", i),
                32'(tgt_sel), 32'(VECS[i].sel));
            if (VECS[i].sel != 6'h0)
                chk(tgt_addr == VECS[i].ta, $sformatf("R2-fold offset vec %0d", i),
                    tgt_addr, VECS[i].ta);
            chk(tgt_we == VECS[i].we, $sformatf("R11 write enable vec %0d", i),
                32'(tgt_we), 32'(VECS[i].we));
            if (VECS[i].we)
                chk(tgt_wdata == VECS[i].twd, $sformatf("R11 write data vec %0d", i),
                    tgt_wdata, VECS[i].twd);
            chk(io_rd_strobe == (!VECS[i].wr && VECS[i].sel[3]),
                $sformatf("R12 io strobe vec %0d", i), 32'(io_rd_strobe),
                32'(!VECS[i].wr && VECS[i].sel[3]));
            @(posedge clk); #2;
            chk(resp_rdata == exp_resp(VECS[i].wr, VECS[i].sz, VECS[i].sel, VECS[i].ta),
                $sformatf("R10 response vec %0d", i), resp_rdata,
                exp_resp(VECS[i].wr, VECS[i].sz, VECS[i].sel, VECS[i].ta));
        end

        // R12: debug access with write and word size still acts as a quiet byte read
        @(negedge clk);
        drive(1'b0, 1'b1, 2'd2, 32'h0400_0003, 32'hFFFF_FFFF, 1'b1);
        #2;
        chk(tgt_sel == 6'b001000, "R12 debug select", 32'(tgt_sel), 32'h08);
        chk(tgt_addr == 32'h3, "R12 debug offset", tgt_addr, 32'h3);
        chk(!tgt_we, "R12 debug no write", 32'(tgt_we), 32'h0);
        chk(!io_rd_strobe, "R12 debug no strobe", 32'(io_rd_strobe), 32'h0);
        @(posedge clk); #2;
        chk(resp_rdata == 32'h43, "R12 debug byte data", resp_rdata, 32'h43);

        // R4: debug byte read of the alias address is not aligned into the alias
        @(negedge clk);
        drive(1'b0, 1'b0, 2'd0, 32'h0400_8001, 32'h0, 1'b1);
        #2;
        chk(tgt_addr == 32'h1, "R4 debug alias miss", tgt_addr, 32'h1);

        // R10: reset in the middle clears a pending response
        @(negedge clk);
        drive(1'b1, 1'b0, 2'd2, 32'h0300_0100, 32'h0, 1'b0);
        rst = 1'b1;
        @(posedge clk); #2;
        chk(resp_rdata == 32'h0, "R10 mid reset", resp_rdata, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #2;
        chk(resp_rdata == pat(2, 32'h100), "R10 after reset", resp_rdata, pat(2, 32'h100));

        finish_run();
    end

endmodule